// File: doc/BRIEF.md
# Second-Operand Shift and Rotate Stage

This combinational stage forms the second operand of a data-processing ALU, together with the shifter carry that the flag logic uses when an instruction updates its flags. It has two modes. In immediate mode, a narrow constant is widened to the full data width and then rotated right by an even count taken from a small rotate field. In register mode, a register value is shifted or rotated by a constant amount carried in the instruction.

The instruction set has no separate shift operations. A plain shift is a move whose second operand passes through this stage. The stage does not take a shift amount from a register, and it contains no ALU. The first encoding of a zero amount for each shift kind has its own meaning, as listed in the requirements below. With the default sizes, data is 32 bits, the constant is 8 bits, the rotate field is 4 bits and the shift amount is 5 bits.

Top module: `opnd2_shifter`

## Requirements
- R1: When `use_imm`=1, `op2` equals `imm_val` zero-extended to 32 bits and rotated right by 2×`imm_rot`.
- R2: In immediate mode, `carry_out` is `op2[31]` when `imm_rot`≠0, and `carry_in` when `imm_rot`=0.
- R3: When `use_imm`=0, `shift_kind` selects the operation: 0 is logical left, 1 is logical right, 2 is arithmetic right, 3 is rotate right. For a logical left shift by n in 1..31, `op2`=`reg_val`<<n and `carry_out`=`reg_val[32-n]`.
- R4: A logical left shift by 0 gives `op2`=`reg_val` and `carry_out`=`carry_in`.
- R5: A logical right shift by n in 1..31 gives `reg_val`>>n with `carry_out`=`reg_val[n-1]`. An amount of 0 means a shift by 32: `op2`=0 and `carry_out`=`reg_val[31]`.
- R6: An arithmetic right shift by n in 1..31 fills with the sign bit, and `carry_out`=`reg_val[n-1]`. An amount of 0 means a shift by 32: every bit of `op2` equals `reg_val[31]`, and `carry_out`=`reg_val[31]`.
- R7: A rotate right by n in 1..31 rotates `reg_val` right by n, and `carry_out`=`reg_val[n-1]`.
- R8: A rotate right by 0 becomes a one-bit rotate through carry: `op2`={`carry_in`,`reg_val[31:1]`} and `carry_out`=`reg_val[0]`.
- R9: In register mode, `imm_val` and `imm_rot` have no effect on the outputs. In immediate mode, `reg_val`, `shift_kind` and `shift_amt` have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| use_imm | input | 1 | 1 selects immediate mode, 0 selects register mode |
| imm_val | input | 8 | Constant to be widened |
| imm_rot | input | 4 | Rotate field; the rotate count is twice this value |
| reg_val | input | 32 | Register value to be shifted |
| shift_kind | input | 2 | 0 LSL, 1 LSR, 2 ASR, 3 ROR/RRX |
| shift_amt | input | 5 | Constant shift amount |
| carry_in | input | 1 | Current carry flag |
| op2 | output | 32 | Second ALU operand |
| carry_out | output | 1 | Shifter carry for the flag logic |

## Verification
Walking-bit and sign-bit register values at amounts 1, 4, 5 and 31 separate left from right shifts and logical from arithmetic fill, and they show which bit becomes the carry. A zero amount under each shift kind tells apart the four special meanings: pass-through, clear, sign fill and rotate through carry. Immediate vectors that use rotate counts 0, 2, 8 and 30 show whether the rotation wraps correctly and whether the carry comes from the rotated result or from the incoming flag. Random operands are compared against a bit-loop reference model, and fields from the unused mode are changed to confirm that they have no effect.

// File: rtl/opnd2_pkg.sv
package opnd2_pkg;
   typedef enum logic [1:0] {
      SK_LSL = 2'd0,
      SK_LSR = 2'd1,
      SK_ASR = 2'd2,
      SK_ROR = 2'd3
   } shift_kind_e;
endpackage

// File: rtl/opnd2_imm_expand.sv
module opnd2_imm_expand #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 8,
   parameter int ROT_W  = 4
) (
   input  logic [IMM_W-1:0]  imm_val,
   input  logic [ROT_W-1:0]  imm_rot,
   input  logic              carry_in,
   output logic [DATA_W-1:0] value,
   output logic              carry
);
   localparam int CNT_W = $clog2(DATA_W);

   logic [DATA_W-1:0]   widened;
   logic [2*DATA_W-1:0] doubled;
   logic [CNT_W-1:0]    count;

   always_comb begin
      widened = {{(DATA_W-IMM_W){1'b0}}, imm_val};
      doubled = {widened, widened};
      count   = CNT_W'({imm_rot, 1'b0});
      value   = doubled[count +: DATA_W];
      carry   = (imm_rot != '0) ? value[DATA_W-1] : carry_in;
   end
endmodule

// File: rtl/opnd2_reg_shift.sv
module opnd2_reg_shift
   import opnd2_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int AMT_W  = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] reg_val,
   input  logic [1:0]        shift_kind,
   input  logic [AMT_W-1:0]  shift_amt,
   input  logic              carry_in,
   output logic [DATA_W-1:0] value,
   output logic              carry
);
   localparam int MSB = DATA_W - 1;

   logic                amt_zero;
   logic [2*DATA_W-1:0] rot_src;
   logic [2*DATA_W-1:0] sgn_src;
   logic [2*DATA_W-1:0] zro_src;
   logic                low_out;
   logic                high_out;

   always_comb begin
      amt_zero = (shift_amt == '0);
      rot_src  = {reg_val, reg_val};
      sgn_src  = {{DATA_W{reg_val[MSB]}}, reg_val};
      zro_src  = {{DATA_W{1'b0}}, reg_val};
      low_out  = amt_zero ? 1'b0 : reg_val[shift_amt - AMT_W'(1)];
      high_out = amt_zero ? 1'b0 : reg_val[AMT_W'(DATA_W) - shift_amt];
      value    = reg_val;
      carry    = carry_in;
      unique case (shift_kind_e'(shift_kind))
         SK_LSL: if (!amt_zero) begin
            value = reg_val << shift_amt;
            carry = high_out;
         end
         SK_LSR: begin
            value = amt_zero ? '0 : zro_src[shift_amt +: DATA_W];
            carry = amt_zero ? reg_val[MSB] : low_out;
         end
         SK_ASR: begin
            value = amt_zero ? {DATA_W{reg_val[MSB]}} : sgn_src[shift_amt +: DATA_W];
            carry = amt_zero ? reg_val[MSB] : low_out;
         end
         SK_ROR: begin
            value = amt_zero ? {carry_in, reg_val[MSB:1]} : rot_src[shift_amt +: DATA_W];
            carry = amt_zero ? reg_val[0] : low_out;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/opnd2_shifter.sv
module opnd2_shifter #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 8,
   parameter int ROT_W  = 4,
   parameter int AMT_W  = $clog2(DATA_W)
) (
   input  logic              use_imm,
   input  logic [IMM_W-1:0]  imm_val,
   input  logic [ROT_W-1:0]  imm_rot,
   input  logic [DATA_W-1:0] reg_val,
   input  logic [1:0]        shift_kind,
   input  logic [AMT_W-1:0]  shift_amt,
   input  logic              carry_in,
   output logic [DATA_W-1:0] op2,
   output logic              carry_out
);
   localparam int MAX_ROT = 2 * ((1 << ROT_W) - 1);

   if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0)
      $error("DATA_W must be a power of two");
   if (IMM_W < 1 || IMM_W > DATA_W)
      $error("IMM_W must lie in 1..DATA_W");
   if (MAX_ROT >= DATA_W)
      $error("ROT_W too wide for DATA_W");
   if (AMT_W != $clog2(DATA_W))
      $error("AMT_W must equal clog2(DATA_W)");

   logic [DATA_W-1:0] imm_value, sh_value;
   logic              imm_carry, sh_carry;

   opnd2_imm_expand #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_imm (
      .imm_val (imm_val),
      .imm_rot (imm_rot),
      .carry_in(carry_in),
      .value   (imm_value),
      .carry   (imm_carry)
   );

   opnd2_reg_shift #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_shift (
      .reg_val   (reg_val),
      .shift_kind(shift_kind),
      .shift_amt (shift_amt),
      .carry_in  (carry_in),
      .value     (sh_value),
      .carry     (sh_carry)
   );

   always_comb begin
      op2       = use_imm ? imm_value : sh_value;
      carry_out = use_imm ? imm_carry : sh_carry;
   end
endmodule

// File: rtl/opnd2_shifter_chk.sv
module opnd2_shifter_chk #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 8,
   parameter int ROT_W  = 4,
   parameter int AMT_W  = $clog2(DATA_W)
) (
   input logic              use_imm,
   input logic [IMM_W-1:0]  imm_val,
   input logic [ROT_W-1:0]  imm_rot,
   input logic [DATA_W-1:0] reg_val,
   input logic [1:0]        shift_kind,
   input logic [AMT_W-1:0]  shift_amt,
   input logic              carry_in,
   input logic [DATA_W-1:0] op2,
   input logic              carry_out
);
   logic known;
   always_comb begin
      known = !$isunknown({use_imm, imm_val, imm_rot, reg_val, shift_kind,
                           shift_amt, carry_in, op2, carry_out});
      if (known) begin
         // rotation keeps the population count of the constant
         p_imm_popcount_r1: assert (!use_imm || $countones(op2) == $countones(imm_val));
         p_imm_carry_r2: assert (!use_imm || imm_rot == '0 || carry_out == op2[DATA_W-1]);
         p_lsl_zero_r4: assert (use_imm || shift_kind != 2'd0 || shift_amt != '0
                                || (op2 == reg_val && carry_out == carry_in));
         p_lsr_full_r5: assert (use_imm || shift_kind != 2'd1 || shift_amt != '0
                                || (op2 == '0 && carry_out == reg_val[DATA_W-1]));
         p_asr_sign_r6: assert (use_imm || shift_kind != 2'd2
                                || op2[DATA_W-1] == reg_val[DATA_W-1]);
         p_ror_carry_r7: assert (use_imm || shift_kind != 2'd3 || shift_amt == '0
                                 || carry_out == op2[DATA_W-1]);
         p_rrx_r8: assert (use_imm || shift_kind != 2'd3 || shift_amt != '0
                           || (op2 == {carry_in, reg_val[DATA_W-1:1]} && carry_out == reg_val[0]));
      end
   end
endmodule

bind opnd2_shifter opnd2_shifter_chk #(
   .DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W), .AMT_W(AMT_W)
) i_opnd2_shifter_chk (.*);

// File: tb/test_opnd2_shifter.sv
module test_opnd2_shifter;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        use_imm;
   logic [7:0]  imm_val;
   logic [3:0]  imm_rot;
   logic [31:0] reg_val;
   logic [1:0]  shift_kind;
   logic [4:0]  shift_amt;
   logic        carry_in;
   logic [31:0] op2;
   logic        carry_out;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   opnd2_shifter i_opnd2_shifter (.*);

   typedef struct packed {
      logic        im;
      logic [7:0]  i8;
      logic [3:0]  rt;
      logic [31:0] rv;
      logic [1:0]  kd;
      logic [4:0]  am;
      logic        ci;
      logic [31:0] eo;
      logic        ec;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 8'hFF, 4'd0,  32'h0,          2'd0, 5'd0,  1'b1, 32'h000000FF, 1'b1}, // R1 R2
      '{1'b1, 8'hFF, 4'd4,  32'h0,          2'd0, 5'd0,  1'b0, 32'hFF000000, 1'b1}, // R1 R2
      '{1'b1, 8'h01, 4'd1,  32'h0,          2'd0, 5'd0,  1'b1, 32'h40000000, 1'b0}, // R1 R2
      '{1'b1, 8'h3F, 4'd15, 32'h0,          2'd0, 5'd0,  1'b1, 32'h000000FC, 1'b0}, // R1 R2
      '{1'b0, 8'h00, 4'd0,  32'h80000001,   2'd0, 5'd1,  1'b0, 32'h00000002, 1'b1}, // R3
      '{1'b0, 8'h00, 4'd0,  32'h00000003,   2'd0, 5'd31, 1'b0, 32'h80000000, 1'b1}, // R3
      '{1'b0, 8'h00, 4'd0,  32'h12345678,   2'd0, 5'd0,  1'b1, 32'h12345678, 1'b1}, // R4
      '{1'b0, 8'h00, 4'd0,  32'h80000010,   2'd1, 5'd5,  1'b0, 32'h04000000, 1'b1}, // R5
      '{1'b0, 8'h00, 4'd0,  32'hC0000000,   2'd1, 5'd31, 1'b0, 32'h00000001, 1'b1}, // R5
      '{1'b0, 8'h00, 4'd0,  32'h80000000,   2'd1, 5'd0,  1'b0, 32'h00000000, 1'b1}, // R5
      '{1'b0, 8'h00, 4'd0,  32'h80000000,   2'd2, 5'd4,  1'b1, 32'hF8000000, 1'b0}, // R6
      '{1'b0, 8'h00, 4'd0,  32'h80000000,   2'd2, 5'd0,  1'b0, 32'hFFFFFFFF, 1'b1}, // R6
      '{1'b0, 8'h00, 4'd0,  32'h7FFFFFFF,   2'd2, 5'd0,  1'b1, 32'h00000000, 1'b0}, // R6
      '{1'b0, 8'h00, 4'd0,  32'h0000001F,   2'd3, 5'd4,  1'b0, 32'hF0000001, 1'b1}, // R7
      '{1'b0, 8'h00, 4'd0,  32'h00000003,   2'd3, 5'd0,  1'b1, 32'h80000001, 1'b1}, // R8
      '{1'b0, 8'h00, 4'd0,  32'h00000002,   2'd3, 5'd0,  1'b0, 32'h00000001, 1'b0}  // R8
   };

   // Bit-loop reference built from the requirements
   function automatic logic [32:0] ref_model(vec_t v);
      logic [31:0] r;
      logic        c;
      int          n;
      r = '0;
      c = v.ci;
      if (v.im) begin
         n = 2 * int'(v.rt);
         for (int i = 0; i < 32; i++) begin
            int src;
            src = (i + n) % 32;
            r[i] = (src < 8) ? v.i8[src] : 1'b0;
         end
         if (v.rt != 0) c = r[31];
      end else begin
         n = int'(v.am);
         case (v.kd)
            2'd0: begin
               for (int i = 0; i < 32; i++) r[i] = (i >= n) ? v.rv[i-n] : 1'b0;
               if (n != 0) c = v.rv[32-n];
            end
            2'd1, 2'd2: begin
               if (n == 0) n = 32;
               for (int i = 0; i < 32; i++)
                  r[i] = (i + n < 32) ? v.rv[i+n] : (v.kd == 2'd2 ? v.rv[31] : 1'b0);
               c = v.rv[n-1];
            end
            default: begin
               if (n == 0) begin
                  for (int i = 0; i < 31; i++) r[i] = v.rv[i+1];
                  r[31] = v.ci;
                  c = v.rv[0];
               end else begin
                  for (int i = 0; i < 32; i++) r[i] = v.rv[(i+n)%32];
                  c = v.rv[n-1];
               end
            end
         endcase
      end
      return {c, r};
   endfunction

   function automatic string tag_of(vec_t v);
      if (v.im) return "R1/R2";
      case (v.kd)
         2'd0: return (v.am == 0) ? "R4" : "R3";
         2'd1: return "R5";
         2'd2: return "R6";
         default: return (v.am == 0) ? "R8" : "R7";
      endcase
   endfunction

   task automatic apply(vec_t v);
      @(posedge clk);
      use_imm = v.im; imm_val = v.i8; imm_rot = v.rt; reg_val = v.rv;
      shift_kind = v.kd; shift_amt = v.am; carry_in = v.ci;
      @(negedge clk);
   endtask

   task automatic check(string req, logic [31:0] eo, logic ec);
      n_checks++;
      if (op2 !== eo || carry_out !== ec) begin
         n_fail++;
         $display("FAIL %s: got op2=%h c=%b, expected op2=%h c=%b", req, op2, carry_out, eo, ec);
      end
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      vec_t v;
      logic [32:0] e, e2;
      // quiescent all-zero inputs give a zero operand and zero carry (R4)
      v = '0;
      apply(v);
      check("R4 idle", 32'h0, 1'b0);

      for (int i = 0; i < NV; i++) begin
         apply(VECS[i]);
         check(tag_of(VECS[i]), VECS[i].eo, VECS[i].ec);
      end

      for (int i = 0; i < 400; i++) begin
         v = '0;
         v.im = ($urandom_range(0, 3) == 0);
         v.i8 = 8'($urandom); v.rt = 4'($urandom);
         v.rv = $urandom; v.kd = 2'($urandom);
         v.am = ($urandom_range(0, 3) == 0) ? 5'd0 : 5'($urandom);
         v.ci = 1'($urandom);
         e = ref_model(v);
         apply(v);
         check(tag_of(v), e[31:0], e[32]);
      end

      // R9: fields of the unused mode do not change the outputs
      for (int i = 0; i < 40; i++) begin
         v = '0;
         v.im = i[0];
         v.i8 = 8'($urandom); v.rt = 4'($urandom);
         v.rv = $urandom; v.kd = 2'($urandom); v.am = 5'($urandom);
         v.ci = 1'($urandom);
         e = ref_model(v);
         if (v.im) begin
            v.rv = ~v.rv; v.kd = ~v.kd; v.am = v.am + 5'd7;
         end else begin
            v.i8 = ~v.i8; v.rt = v.rt + 4'd5;
         end
         e2 = e;
         apply(v);
         check("R9", e2[31:0], e2[32]);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule